// File: doc/BRIEF.md
# SIMD Wavefront Issue Scheduler

This block selects which resident wavefront drives a 16-lane SIMD array. A wavefront holds 64 threads. The array runs it in four consecutive cycles, one group of 16 threads per cycle. The scheduler therefore makes a choice once per four-cycle slot. Each slot either issues one wavefront or is left idle.

Each resident wavefront supplies two flags: a valid flag, and a flag saying whether its next instruction needs the result of the instruction it issued before. A result becomes usable eight cycles after its instruction started. A dependent wavefront is held back until then, and another eligible wavefront fills the slot in between. With two dependent wavefronts alternating, no cycle is lost. When several wavefronts are eligible, the choice goes round-robin, starting after the wavefront that was issued last. A per-wavefront retire input drops any pending result wait for that wavefront.

The control is a state machine with three states. ST_START is entered on reset and lasts one cycle. ST_ISSUE drives one wavefront's quarters. ST_BUBBLE is an idle slot. A decision point is either the ST_START cycle or the last quarter of a slot. At a decision point there are two transitions: to ST_ISSUE when any wavefront is eligible, and to ST_BUBBLE otherwise. In every other cycle the state holds and only the quarter counter advances.

Top module: `wf_issue_sched`

## Requirements
- R1: While reset is asserted, issue_vld, bubble and lane_en are all 0. The first slot begins in the first cycle after reset is released, and the search order after reset starts at wavefront 0.
- R2: Every slot lasts exactly four cycles. During a slot, issue_quarter counts 0, 1, 2, 3 and thread_base equals 16 × issue_quarter, so quarter q covers threads 16q to 16q+15. issue_wf stays constant for the whole slot.
- R3: lane_en is all ones (16'hFFFF) in every cycle that issue_vld is 1, and 16'h0000 in every other cycle.
- R4: A wavefront is eligible when it is valid and either its dependence flag is 0 or its previous result is ready. A result is ready 8 cycles after the first quarter of its instruction. A dependent wavefront that was issued in the previous slot is therefore not issued again in the next slot.
- R5: A valid wavefront whose dependence flag is 0 may issue in back-to-back slots.
- R6: Among eligible wavefronts, the one picked is the first found searching upward (modulo 4) from the last issued wavefront ID plus one.
- R7: Two valid dependent wavefronts alternate slot by slot with no idle slot between them.
- R8: When no wavefront is eligible at a decision point, the next slot is an idle slot. bubble is 1 and issue_vld is 0 for all four of its cycles.
- R9: Inputs are sampled only at decision points. A change to wf_valid or wf_dep in the middle of a slot does not alter that slot.
- R10: A 1 on wf_retire[i] clears wavefront i's pending result wait, so at the next decision point it is eligible even if its dependence flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wf_valid | input | 4 | Wavefront i is resident and has an instruction |
| wf_dep | input | 4 | Next instruction of wavefront i needs its previous result |
| wf_retire | input | 4 | Clears the pending result wait of wavefront i |
| issue_vld | output | 1 | A wavefront is being issued this cycle |
| issue_wf | output | 2 | ID of the issued wavefront |
| issue_quarter | output | 2 | Quarter of the wavefront executing this cycle |
| thread_base | output | 6 | First thread ID of the current quarter |
| lane_en | output | 16 | Per-lane enable for the SIMD array |
| bubble | output | 1 | Idle-slot cycle |

## Verification
The bench goes after the latency boundary: a lone dependent wavefront must leave exactly one idle slot before it returns. A design that counted the latency from the wrong cycle would either reissue it at once or idle for two slots. Two dependent wavefronts must alternate with no gap, which exposes a design that waits too long. Other cases check the round-robin order across skipped IDs, where a design that restarts its search at zero would repeat the low IDs. They also drop a valid flag mid-slot, which catches a design that decides every cycle, and pulse retire just after issue, where a design that ignores retire would insert an idle slot.

// File: rtl/wf_sched_pkg.sv
package wf_sched_pkg;
    typedef enum logic [1:0] {
        ST_START  = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_BUBBLE = 2'd2
    } sched_state_e;
endpackage

// File: rtl/wf_ready_tracker.sv
module wf_ready_tracker #(
    parameter int NWF     = 4,
    parameter int RAW_LAT = 8,
    localparam int IDW    = $clog2(NWF),
    localparam int CW     = $clog2(RAW_LAT)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_pulse,
    input  logic [IDW-1:0] start_id,
    input  logic [NWF-1:0] retire,
    output logic [NWF-1:0] ready
);
    for (genvar i = 0; i < NWF; i++) begin : g_wf
        logic [CW-1:0] wait_cnt;
        always_ff @(posedge clk) begin
            if (!rst_n || retire[i]) begin
                wait_cnt <= '0;
            end else if (start_pulse && start_id == IDW'(i)) begin
                wait_cnt <= CW'(RAW_LAT - 1);
            end else if (wait_cnt != '0) begin
                wait_cnt <= wait_cnt - CW'(1);
            end
        end
        assign ready[i] = (wait_cnt == '0);
    end
endmodule

// File: rtl/wf_rr_picker.sv
module wf_rr_picker #(
    parameter int NWF  = 4,
    localparam int IDW = $clog2(NWF)
) (
    input  logic [NWF-1:0] elig,
    input  logic [IDW-1:0] last_id,
    output logic           found,
    output logic [IDW-1:0] pick
);
    always_comb begin
        int idx;
        found = 1'b0;
        pick  = '0;
        for (int k = NWF; k >= 1; k--) begin
            idx = (int'(last_id) + k) % NWF;
            if (elig[IDW'(idx)]) begin
                found = 1'b1;
                pick  = IDW'(idx);
            end
        end
    end
endmodule

// File: rtl/wf_issue_sched.sv
module wf_issue_sched
    import wf_sched_pkg::*;
#(
    parameter int NWF        = 4,
    parameter int WF_THREADS = 64,
    parameter int LANES      = 16,
    parameter int RAW_LAT    = 8,
    localparam int IDW       = $clog2(NWF),
    localparam int QUARTERS  = WF_THREADS / LANES,
    localparam int QW        = $clog2(QUARTERS),
    localparam int TBW       = $clog2(WF_THREADS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NWF-1:0]   wf_valid,
    input  logic [NWF-1:0]   wf_dep,
    input  logic [NWF-1:0]   wf_retire,
    output logic             issue_vld,
    output logic [IDW-1:0]   issue_wf,
    output logic [QW-1:0]    issue_quarter,
    output logic [TBW-1:0]   thread_base,
    output logic [LANES-1:0] lane_en,
    output logic             bubble
);
    sched_state_e   state_q, state_d;
    logic [QW-1:0]  quarter_q;
    logic [IDW-1:0] cur_wf_q;
    logic [IDW-1:0] last_wf_q;
    logic [NWF-1:0] ready;
    logic [NWF-1:0] elig;
    logic           found;
    logic [IDW-1:0] pick;
    logic           decide;

    assign decide = (state_q == ST_START) || (quarter_q == QW'(QUARTERS - 1));
    assign elig   = wf_valid & (~wf_dep | ready);

    wf_ready_tracker #(.NWF(NWF), .RAW_LAT(RAW_LAT)) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_pulse(decide && found),
        .start_id   (pick),
        .retire     (wf_retire),
        .ready      (ready)
    );

    wf_rr_picker #(.NWF(NWF)) u_picker (
        .elig   (elig),
        .last_id(last_wf_q),
        .found  (found),
        .pick   (pick)
    );

    always_comb begin
        state_d = state_q;
        if (decide) begin
            unique case (state_q)
                ST_START, ST_ISSUE, ST_BUBBLE: state_d = found ? ST_ISSUE : ST_BUBBLE;
                default:                       state_d = ST_BUBBLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_START;
            quarter_q <= '0;
            cur_wf_q  <= '0;
            last_wf_q <= IDW'(NWF - 1);
        end else begin
            state_q <= state_d;
            if (decide) begin
                quarter_q <= '0;
                if (found) begin
                    cur_wf_q  <= pick;
                    last_wf_q <= pick;
                end
            end else begin
                quarter_q <= quarter_q + QW'(1);
            end
        end
    end

    always_comb begin
        issue_vld     = 1'b0;
        bubble        = 1'b0;
        issue_wf      = cur_wf_q;
        issue_quarter = quarter_q;
        thread_base   = TBW'(int'(quarter_q) * LANES);
        unique case (state_q)
            ST_START:  begin end
            ST_ISSUE:  issue_vld = 1'b1;
            ST_BUBBLE: bubble    = 1'b1;
            default:   begin end
        endcase
        lane_en = {LANES{issue_vld}};
    end
endmodule

// File: rtl/wf_issue_sched_chk.sv
module wf_issue_sched_chk #(
    parameter int NWF        = 4,
    parameter int WF_THREADS = 64,
    parameter int LANES      = 16,
    localparam int IDW       = $clog2(NWF),
    localparam int QUARTERS  = WF_THREADS / LANES,
    localparam int QW        = $clog2(QUARTERS),
    localparam int TBW       = $clog2(WF_THREADS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NWF-1:0]   wf_dep,
    input logic [NWF-1:0]   wf_retire,
    input logic             issue_vld,
    input logic [IDW-1:0]   issue_wf,
    input logic [QW-1:0]    issue_quarter,
    input logic [TBW-1:0]   thread_base,
    input logic [LANES-1:0] lane_en,
    input logic             bubble
);
    // R1 R8
    vld_bubble_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_vld && bubble));

    // R2
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((issue_vld || bubble) && issue_quarter != QW'(QUARTERS - 1)) |=>
        (issue_quarter == $past(issue_quarter) + QW'(1) &&
         issue_vld == $past(issue_vld) && issue_wf == $past(issue_wf)));

    // R2
    thread_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(thread_base) == int'(issue_quarter) * LANES);

    // R3
    lane_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vld ? (lane_en == {LANES{1'b1}}) : (lane_en == '0));

    // R4
    raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && issue_quarter == '0 && $past(issue_vld, 4) &&
         $past(issue_wf, 4) == issue_wf &&
         (($past(wf_retire, 1) | $past(wf_retire, 2) |
           $past(wf_retire, 3) | $past(wf_retire, 4)) == '0))
        |-> !$past(wf_dep[issue_wf], 1));
endmodule

bind wf_issue_sched wf_issue_sched_chk #(
    .NWF(NWF), .WF_THREADS(WF_THREADS), .LANES(LANES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wf_dep(wf_dep), .wf_retire(wf_retire),
    .issue_vld(issue_vld), .issue_wf(issue_wf), .issue_quarter(issue_quarter),
    .thread_base(thread_base), .lane_en(lane_en), .bubble(bubble)
);

// File: tb/wf_issue_sched_tb.sv
module wf_issue_sched_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  wf_valid = '0;
    logic [3:0]  wf_dep = '0;
    logic [3:0]  wf_retire = '0;
    logic        issue_vld;
    logic [1:0]  issue_wf;
    logic [1:0]  issue_quarter;
    logic [5:0]  thread_base;
    logic [15:0] lane_en;
    logic        bubble;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wf_issue_sched u_dut (
        .clk(clk), .rst_n(rst_n), .wf_valid(wf_valid), .wf_dep(wf_dep),
        .wf_retire(wf_retire), .issue_vld(issue_vld), .issue_wf(issue_wf),
        .issue_quarter(issue_quarter), .thread_base(thread_base),
        .lane_en(lane_en), .bubble(bubble)
    );

    // slot code: 3'b1xx idle slot, else {1'b0, wavefront id}
    localparam logic [2:0] BB = 3'b100;
    localparam int NV = 9;
    // {valid, dep, slot0, slot1, slot2, slot3}
    localparam logic [19:0] VEC [NV] = '{
        {4'b0011, 4'b0011, 3'd0, 3'd1, 3'd0, 3'd1},  // R7
        {4'b0001, 4'b0001, 3'd0, BB,   3'd0, BB  },  // R4 R8
        {4'b0001, 4'b0000, 3'd0, 3'd0, 3'd0, 3'd0},  // R5
        {4'b1111, 4'b0000, 3'd0, 3'd1, 3'd2, 3'd3},  // R6
        {4'b0101, 4'b0101, 3'd0, 3'd2, 3'd0, 3'd2},  // R6 R7
        {4'b0000, 4'b0000, BB,   BB,   BB,   BB  },  // R8
        {4'b1111, 4'b1111, 3'd0, 3'd1, 3'd2, 3'd3},  // R4 R6
        {4'b1000, 4'b1000, 3'd3, BB,   3'd3, BB  },  // R6 R8
        {4'b0011, 4'b0001, 3'd0, 3'd1, 3'd0, 3'd1}   // R4 R5
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int slot_code();
        if (bubble) return 4;
        if (issue_vld) return int'(issue_wf);
        return 7;
    endfunction

    task automatic restart(input logic [3:0] v, input logic [3:0] d);
        @(negedge clk);
        rst_n = 1'b0;
        wf_valid = v;
        wf_dep = d;
        wf_retire = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    initial begin
        // R1: reset state
        @(negedge clk);
        #5;
        check("R1 reset issue_vld", int'(issue_vld), 0);
        check("R1 reset bubble", int'(bubble), 0);
        check("R1 reset lane_en", int'(lane_en), 0);

        for (int v = 0; v < NV; v++) begin
            restart(VEC[v][19:16], VEC[v][15:12]);
            for (int s = 0; s < 4; s++) begin
                for (int q = 0; q < 4; q++) begin
                    logic [2:0] ex;
                    ex = VEC[v][11 - 3*s -: 3];
                    step();
                    check($sformatf("R2 quarter vec%0d", v), int'(issue_quarter), q);
                    check($sformatf("R2 thread_base vec%0d", v), int'(thread_base), 16*q);
                    check($sformatf("R3 lane_en vec%0d", v), int'(lane_en),
                          ex[2] ? 0 : 16'hFFFF);
                    check($sformatf("R4-sched slot vec%0d s%0d q%0d", v, s, q),
                          slot_code(), ex[2] ? 4 : int'(ex));
                end
            end
        end

        // R9: valid dropped mid-slot leaves the slot intact
        restart(4'b0011, 4'b0000);
        step();
        check("R9 slot start", slot_code(), 0);
        @(negedge clk);
        wf_valid = 4'b0010;
        step();
        step();
        check("R9 mid-slot q2", slot_code(), 0);
        step();
        check("R9 mid-slot q3", slot_code(), 0);
        check("R9 mid-slot quarter", int'(issue_quarter), 3);
        step();
        check("R9 next slot", slot_code(), 1);
        repeat (4) step();
        check("R9 after drop", slot_code(), 1);

        // R10: retire clears the result wait of a dependent wavefront
        restart(4'b0001, 4'b0001);
        step();
        check("R10 first issue", slot_code(), 0);
        @(negedge clk);
        wf_retire = 4'b0001;
        @(negedge clk);
        wf_retire = 4'b0000;
        step();
        step();
        step();
        check("R10 reissue after retire", slot_code(), 0);
        check("R10 reissue quarter", int'(issue_quarter), 0);

        // R1: first slot after release starts at wavefront 0
        restart(4'b0110, 4'b0000);
        step();
        check("R1 first pick", slot_code(), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule